// File: doc/BRIEF.md
# Sample-Clocked Heartbeat Pulse Generator

This block produces a slow square-wave heartbeat on an open-drain pin so that an external controller can see that the audio processor is still running. The pulse does not count system clock cycles. It counts rising edges of the audio frame (left/right) clock. If the audio clock stops, for example when a slave-mode link loses its upstream clock, the heartbeat stops as well. The controller can then tell that the signal path is stalled, not only that the chip has power.

The heartbeat period is programmed in 10 ms steps with a code from 1 to 64, giving 10 ms to 640 ms. After reset the code is 20 (200 ms). A sample-rate select input sets how many frame-clock edges make up one 10 ms step. Time is counted in frames, so the period is only correct when this select matches the real sample rate. A new code or rate is held back until the next toggle, so a half period that has already started is never stretched or cut short. An enable input parks the pin in its released state and restarts the count.

Top module: `wdog_beat`

## Requirements
- R1: After reset, `wd_pull` is 0 (pin released) and the active code is 20. With `en` high from reset, the first toggle of `wd_pull` occurs on the floor(20*STEP_48K/2)-th rising edge of `lrck`.
- R2: While enabled, `wd_pull` toggles once every floor(code*step/2) rising edges of `lrck`. The value of step depends on `rate_sel`: 0 selects STEP_48K, 1 selects STEP_44K, 2 selects STEP_32K and 3 selects STEP_48K. Falling edges of `lrck` are not counted.
- R3: A write (`per_wr` high for one cycle) stores `per_code` clamped to the range 1..64. A value of 0 is stored as 1, and any value above 64 is stored as 64.
- R4: A written code takes effect at the next toggle. The half period in progress when the write occurs keeps its old length.
- R5: `rate_sel` is captured at each toggle (and continuously while disabled). A change in the middle of a half period affects only the following half periods.
- R6: While no `lrck` rising edge arrives, `wd_pull` holds its value and the count is kept. When edges resume, the count continues from where it stopped.
- R7: While `en` is low, `wd_pull` is 0 from the next cycle on and the count is cleared. When `en` returns high, a full half period counted with the latest written code and the current `rate_sel` precedes the first toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Audio frame clock, asynchronous to clk, synchronised inside |
| en | input | 1 | Heartbeat enable |
| per_wr | input | 1 | One-cycle write strobe for the period code |
| per_code | input | 7 | Period code in 10 ms steps (1..64, clamped) |
| rate_sel | input | 2 | Sample-rate select: 0 = 48 kHz, 1 = 44.1 kHz, 2 = 32 kHz, 3 = 48 kHz |
| wd_pull | output | 1 | Open-drain enable: 1 pulls the pin low, 0 releases it |

## Verification
The bench counts frame-clock edges between successive toggles. It writes new codes and rates in the middle of a half period and checks that the half period in progress keeps its length. A design that applied the change immediately would produce a short or long half period at that point. The bench also writes the out-of-range codes 0 and 100. A design without clamping would stall with a zero-length count or run a wrapped count far from 64 steps. It checks an odd step at 44.1 kHz to confirm the floor rounding. It stops the frame clock in the middle of a half period and checks that the pin holds and the count resumes rather than restarts. It disables the block in the middle of a high phase and checks that the pin is released and a full fresh half period follows re-enable.

// File: rtl/wdog_beat.sv
module wdog_beat #(
  parameter int CODE_W   = 7,
  parameter int CODE_MAX = 64,
  parameter int CODE_DEF = 20,
  parameter int STEP_48K = 480,
  parameter int STEP_44K = 441,
  parameter int STEP_32K = 320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lrck,
  input  logic              en,
  input  logic              per_wr,
  input  logic [CODE_W-1:0] per_code,
  input  logic [1:0]        rate_sel,
  output logic              wd_pull
);

  localparam int STEP_MAX = (STEP_48K > STEP_44K) ?
                            ((STEP_48K > STEP_32K) ? STEP_48K : STEP_32K) :
                            ((STEP_44K > STEP_32K) ? STEP_44K : STEP_32K);
  localparam int MAXH = (CODE_MAX * STEP_MAX) / 2;
  localparam int CW   = $clog2(MAXH + 1);
  localparam int PW   = CW + 1;

  logic [2:0]        lr_s;
  logic              lr_rise;
  logic [CODE_W-1:0] pend_code, act_code, wr_code;
  logic [1:0]        act_rate;
  logic [PW-1:0]     step, prod;
  logic [CW-1:0]     half, cnt;
  logic              term;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lr_s <= '0;
    else        lr_s <= {lr_s[1:0], lrck};

  assign lr_rise = lr_s[1] & ~lr_s[2];

  assign wr_code = (per_code == '0) ? CODE_W'(1) :
                   (per_code > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : per_code;

  always_comb
    case (act_rate)
      2'd1:    step = PW'(STEP_44K);
      2'd2:    step = PW'(STEP_32K);
      default: step = PW'(STEP_48K);
    endcase

  assign prod = PW'(act_code) * step;
  assign half = prod[PW-1:1];
  assign term = (cnt >= half - CW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pend_code <= CODE_W'(CODE_DEF);
    else if (per_wr) pend_code <= wr_code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt      <= '0;
      wd_pull  <= 1'b0;
      act_code <= CODE_W'(CODE_DEF);
      act_rate <= 2'd0;
    end else if (!en) begin
      cnt      <= '0;
      wd_pull  <= 1'b0;
      act_code <= pend_code;
      act_rate <= rate_sel;
    end else if (lr_rise) begin
      if (term) begin
        cnt      <= '0;
        wd_pull  <= ~wd_pull;
        act_code <= pend_code;
        act_rate <= rate_sel;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end

endmodule

// File: rtl/wdog_beat_chk.sv
module wdog_beat_chk #(
  parameter int CODE_W   = 7,
  parameter int CODE_MAX = 64,
  parameter int CW       = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              lr_rise,
  input logic              wd_pull,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     half,
  input logic [CODE_W-1:0] act_code,
  input logic [CODE_W-1:0] pend_code
);

  a_r7_released_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wd_pull);

  a_r6_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !lr_rise) |=> $stable(wd_pull));

  a_r2_count_below_half: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < half);

  a_r3_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code >= CODE_W'(1)) && (act_code <= CODE_W'(CODE_MAX)) &&
    (pend_code >= CODE_W'(1)) && (pend_code <= CODE_W'(CODE_MAX)));

  a_r4_code_held_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !lr_rise) |=> $stable(act_code));

endmodule

bind wdog_beat wdog_beat_chk #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .lr_rise(lr_rise), .wd_pull(wd_pull),
  .cnt(cnt), .half(half), .act_code(act_code), .pend_code(pend_code)
);

// File: tb/wdog_beat_bench.sv
module wdog_beat_bench;
  localparam int S48 = 12, S44 = 9, S32 = 8;

  logic       clk = 0, rst_n = 0, lrck = 0, en = 1, per_wr = 0;
  logic [6:0] per_code = '0;
  logic [1:0] rate_sel = 2'd0;
  logic       wd_pull;
  int checks = 0, fails = 0, cycles = 0;

  wdog_beat #(.STEP_48K(S48), .STEP_44K(S44), .STEP_32K(S32)) u_wdog_beat (
    .clk(clk), .rst_n(rst_n), .lrck(lrck), .en(en), .per_wr(per_wr),
    .per_code(per_code), .rate_sel(rate_sel), .wd_pull(wd_pull));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      $display("FAIL watchdog: actual=%0d cycles expected below 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
    end
  end

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample();
    @(negedge clk) lrck = 1;
    repeat (4) @(negedge clk);
    lrck = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic samples(input int n);
    for (int i = 0; i < n; i++) sample();
  endtask

  task automatic half_len(output int n);
    logic s0;
    s0 = wd_pull;
    n = 0;
    while (n < 1000 && wd_pull == s0) begin
      sample();
      n++;
    end
  endtask

  task automatic write_code(input int c);
    @(negedge clk) begin per_code = 7'(c); per_wr = 1; end
    @(negedge clk) per_wr = 0;
  endtask

  task automatic t_reset();
    int n;
    check(int'(wd_pull), 0, "R1 reset released");
    half_len(n); check(n, 20*S48/2, "R1 first half default");
    check(int'(wd_pull), 1, "R1 pulls after first toggle");
    half_len(n); check(n, 20*S48/2, "R2 second half");
  endtask

  task automatic t_rates();
    int n;
    rate_sel = 2'd2;
    half_len(n); check(n, 20*S48/2, "R5 rate change deferred");
    half_len(n); check(n, 20*S32/2, "R2 32k step");
    samples(10); rate_sel = 2'd1;
    half_len(n); check(n, 20*S32/2 - 10, "R5 mid-half rate change");
    half_len(n); check(n, 20*S44/2, "R2 44k step");
    rate_sel = 2'd3;
    half_len(n); check(n, 20*S44/2, "R5 deferred to 48k");
    half_len(n); check(n, 20*S48/2, "R2 code 3 maps to 48k");
  endtask

  task automatic t_write();
    int n;
    rate_sel = 2'd1;
    half_len(n); check(n, 20*S48/2, "R5 deferred to 44k");
    samples(5); write_code(3);
    half_len(n); check(n, 20*S44/2 - 5, "R4 current half kept");
    half_len(n); check(n, (3*S44)/2, "R2 odd product floors");
  endtask

  task automatic t_clamp();
    int n;
    rate_sel = 2'd0; write_code(0);
    half_len(n); check(n, (3*S44)/2, "R4 old code finishes");
    half_len(n); check(n, S48/2, "R3 code 0 clamps to 1");
    write_code(100);
    half_len(n); check(n, S48/2, "R4 old code finishes");
    half_len(n); check(n, 64*S48/2, "R3 code above 64 clamps");
  endtask

  task automatic t_stall();
    int n;
    logic s0;
    write_code(4);
    half_len(n); check(n, 64*S48/2, "R4 before stall");
    samples(10);
    s0 = wd_pull;
    repeat (300) @(negedge clk);
    check(int'(wd_pull), int'(s0), "R6 holds without frame clock");
    half_len(n); check(n, 4*S48/2 - 10, "R6 count resumes");
  endtask

  task automatic t_disable();
    int n;
    if (wd_pull == 1'b0) half_len(n);
    check(int'(wd_pull), 1, "R7 setup high phase");
    samples(5);
    @(negedge clk) en = 0;
    @(negedge clk);
    check(int'(wd_pull), 0, "R7 released when disabled");
    write_code(2); rate_sel = 2'd2;
    samples(30);
    check(int'(wd_pull), 0, "R7 stays released");
    @(negedge clk) en = 1;
    half_len(n); check(n, 2*S32/2, "R7 fresh half with new code");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rates();
    t_write();
    t_clamp();
    t_stall();
    t_disable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule